// File: doc/BRIEF.md
# Banked Uop Fetch Reorder Aligner

This block is the delivery path of a decoded-uop cache. The cache is built from four banks. Each bank returns four uops per access, so one set line holds sixteen uops. A cached block may occupy any subset of the four banks in one set. Its uops are laid out back-to-front: the uop that ends the block sits in the lowest position, and earlier uops sit in higher positions. A fetch therefore names the banks the block occupies and an entry offset, which is the number of uops from the entry point up to and including the block's last uop.

Each cycle the block accepts up to two access descriptors. It reads the addressed bank rows from an internal register array and gathers each block's banks into one contiguous reversed sequence (the first stage). A pipeline register follows. The second stage then reverses each block into program order and packs both blocks into sixteen output slots, first block first, with empty slots invalid and zero.

When the two descriptors claim a common bank, the first is served and the second is parked for one cycle. A conflict pulse travels with the first block's output. A write port fills the register array. Tag checking and next-block prediction are outside this block.

Top module: `uop_fetch_aligner`

## Requirements
- R1: While and after reset, all outputs are zero except `acc_ready`, which is 1, and the register array reads as zero.
- R2: Storage layout. A block with mask M lives in the banks whose bit is set in M, taken in ascending bank order. Reversed position p (0 = the block's last uop) is slot p mod 4 of the (p div 4)-th selected bank. Output slot 0 carries the block's first uop in program order.
- R3: An access with offset K (1..4·popcount(M)) delivers exactly K uops. These are reversed positions K-1 down to 0, in that order, in slots 0..K-1.
- R4: Output latency is two cycles. An access sampled at clock edge k appears after edge k+1 and not after edge k.
- R5: Two valid accesses with disjoint masks are served together. The first access fills slots 0..K0-1 and the second fills slots K0..K0+K1-1.
- R6: Two accesses with disjoint masks may address different sets and are still both delivered in the same cycle.
- R7: If both accesses are valid and their masks share any bank, only the first is delivered, with `out_conflict` = 1. The second follows alone one cycle later with `out_conflict` = 0. `acc_ready` is 0 for exactly the cycle after the conflict, and accesses presented in that cycle are ignored.
- R8: An access whose offset exceeds 4·popcount(mask) delivers no uops and sets `out_offset_err` with its output cycle. The other access of the pair is still delivered, starting at slot 0.
- R9: Slots beyond the delivered total have valid 0 and data 0. `out_count` equals the number of valid slots. An offset of 0 delivers nothing and raises no error.
- R10: A mask with gaps (for example 4'b1010) reads the selected banks in ascending order and skips unselected banks.
- R11: A write with `wr_en` = 1 stores `wr_uop` at (set, bank, slot) on the clock edge. Accesses sampled from the next edge on return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc0_valid | input | 1 | First access descriptor valid |
| acc0_set | input | 2 | First access set index |
| acc0_mask | input | 4 | First access bank mask, bit b = bank b |
| acc0_ofs | input | 5 | First access entry offset, in uops from the block end |
| acc1_valid | input | 1 | Second access descriptor valid |
| acc1_set | input | 2 | Second access set index |
| acc1_mask | input | 4 | Second access bank mask |
| acc1_ofs | input | 5 | Second access entry offset |
| acc_ready | output | 1 | Accesses are accepted this cycle |
| wr_en | input | 1 | Array write enable |
| wr_set | input | 2 | Write set index |
| wr_bank | input | 2 | Write bank index |
| wr_slot | input | 2 | Write slot within the bank row |
| wr_uop | input | 16 | Uop written |
| out_valid | output | 16 | Per-slot valid, bit j = slot j |
| out_uops | output | 256 | Slot j at bits [16j+15:16j] |
| out_count | output | 5 | Number of valid slots |
| out_conflict | output | 1 | Output shows a first block whose partner was deferred |
| out_offset_err | output | 1 | An access of this output cycle had an out-of-range offset |

## Verification
A wrong gather in the first stage appears as slots carrying the wrong bank's tag two cycles after the access, even when the valid pattern is correct. A fault in the hold register shows either as the second block never arriving, or as `acc_ready` staying low past one cycle. A wrong packing offset shows as a gap in `out_valid`, or as the second block overwriting the first, in the same output cycle. An out-of-range offset check that is too loose lets uops through with the error flag low exactly two cycles later.

// File: rtl/ufa_pkg.sv
package ufa_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BANK_UOPS = 4;
    localparam int NUM_SETS  = 4;
    localparam int UOP_W     = 16;

    localparam int LINE_UOPS = NUM_BANKS * BANK_UOPS;
    localparam int SET_W     = $clog2(NUM_SETS);
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int SLOT_W    = $clog2(BANK_UOPS);
    localparam int IDX_W     = $clog2(LINE_UOPS);
    localparam int CNT_W     = $clog2(LINE_UOPS + 1);

    typedef logic [UOP_W-1:0]                 uop_t;
    typedef uop_t [BANK_UOPS-1:0]             bank_row_t;
    typedef bank_row_t [NUM_BANKS-1:0]        banks_t;
    typedef uop_t [LINE_UOPS-1:0]             line_t;

    typedef struct packed {
        logic                 vld;
        logic [SET_W-1:0]     set;
        logic [NUM_BANKS-1:0] mask;
        logic [CNT_W-1:0]     ofs;
    } acc_t;

    typedef struct packed {
        logic             err;
        logic [CNT_W-1:0] cnt;
        line_t            rev;
    } blk_t;

    function automatic int mask_pop(logic [NUM_BANKS-1:0] m);
        int n;
        n = 0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (m[b]) n++;
        end
        return n;
    endfunction

    function automatic int nth_bank(logic [NUM_BANKS-1:0] m, int n);
        int seen;
        int r;
        seen = 0;
        r = 0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (m[b]) begin
                if (seen == n) r = b;
                seen++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ufa_bank_array.sv
module ufa_bank_array
    import ufa_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [SET_W-1:0]                   wr_set,
    input  logic [BANK_W-1:0]                  wr_bank,
    input  logic [SLOT_W-1:0]                  wr_slot,
    input  uop_t                               wr_uop,
    input  logic [NUM_BANKS-1:0][SET_W-1:0]    rd_set,
    output banks_t                             rd_rows
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_row_t mem_q [NUM_SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < NUM_SETS; s++) mem_q[s] <= '0;
            end else if (wr_en && wr_bank == BANK_W'(b)) begin
                mem_q[wr_set][wr_slot] <= wr_uop;
            end
        end

        assign rd_rows[b] = mem_q[rd_set[b]];
    end
endmodule

// File: rtl/ufa_arbiter.sv
module ufa_arbiter
    import ufa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc0,
    input  acc_t acc1,
    output logic ready,
    output acc_t first,
    output acc_t second,
    output logic conflict
);
    logic hold_q;
    acc_t held_q;
    acc_t in0, in1;
    logic overlap;

    assign ready = ~hold_q;

    always_comb begin
        in0 = acc0;
        in1 = acc1;
        in0.vld = acc0.vld & ready;
        in1.vld = acc1.vld & ready;
        overlap = in0.vld & in1.vld & (|(in0.mask & in1.mask));
        if (hold_q) begin
            first    = held_q;
            second   = '0;
            conflict = 1'b0;
        end else begin
            first    = in0;
            second   = overlap ? '0 : in1;
            conflict = overlap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            held_q <= '0;
        end else begin
            hold_q <= overlap;
            held_q <= overlap ? in1 : '0;
        end
    end
endmodule

// File: rtl/ufa_bank_reorder.sv
module ufa_bank_reorder
    import ufa_pkg::*;
(
    input  logic                 vld,
    input  logic [NUM_BANKS-1:0] mask,
    input  logic [CNT_W-1:0]     ofs,
    input  banks_t               rows,
    output blk_t                 blk
);
    int n_banks;
    int bsel;

    always_comb begin
        blk     = '0;
        n_banks = mask_pop(mask);
        bsel    = 0;
        for (int s = 0; s < NUM_BANKS; s++) begin
            if (s < n_banks) begin
                bsel = nth_bank(mask, s);
                for (int u = 0; u < BANK_UOPS; u++) begin
                    blk.rev[s*BANK_UOPS + u] = rows[BANK_W'(bsel)][u];
                end
            end
        end
        blk.err = vld && (int'(ofs) > n_banks * BANK_UOPS);
        blk.cnt = (vld && !blk.err) ? ofs : '0;
    end
endmodule

// File: rtl/ufa_align.sv
module ufa_align
    import ufa_pkg::*;
(
    input  logic [CNT_W-1:0]     a_cnt,
    input  line_t                a_rev,
    input  logic [CNT_W-1:0]     b_cnt,
    input  line_t                b_rev,
    output logic [LINE_UOPS-1:0] slot_vld,
    output line_t                slot_uop,
    output logic [CNT_W-1:0]     total
);
    int ca, cb;

    always_comb begin
        slot_vld = '0;
        slot_uop = '0;
        ca = int'(a_cnt);
        cb = int'(b_cnt);
        for (int j = 0; j < LINE_UOPS; j++) begin
            if (j < ca) begin
                slot_vld[j] = 1'b1;
                slot_uop[j] = a_rev[IDX_W'(ca - 1 - j)];
            end else if (j - ca < cb) begin
                slot_vld[j] = 1'b1;
                slot_uop[j] = b_rev[IDX_W'(cb - 1 - (j - ca))];
            end
        end
        total = CNT_W'(ca + cb);
    end
endmodule

// File: rtl/uop_fetch_aligner.sv
module uop_fetch_aligner
    import ufa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc0_valid,
    input  logic [SET_W-1:0]            acc0_set,
    input  logic [NUM_BANKS-1:0]        acc0_mask,
    input  logic [CNT_W-1:0]            acc0_ofs,
    input  logic                        acc1_valid,
    input  logic [SET_W-1:0]            acc1_set,
    input  logic [NUM_BANKS-1:0]        acc1_mask,
    input  logic [CNT_W-1:0]            acc1_ofs,
    output logic                        acc_ready,
    input  logic                        wr_en,
    input  logic [SET_W-1:0]            wr_set,
    input  logic [BANK_W-1:0]           wr_bank,
    input  logic [SLOT_W-1:0]           wr_slot,
    input  logic [UOP_W-1:0]            wr_uop,
    output logic [LINE_UOPS-1:0]        out_valid,
    output logic [LINE_UOPS*UOP_W-1:0]  out_uops,
    output logic [CNT_W-1:0]            out_count,
    output logic                        out_conflict,
    output logic                        out_offset_err
);
    acc_t a0, a1, first, second;
    logic conflict;
    logic [NUM_BANKS-1:0][SET_W-1:0] bank_set;
    banks_t rows;
    blk_t   blk_a, blk_b;
    blk_t   s1_a_q, s1_b_q;
    logic   s1_conf_q;
    logic [LINE_UOPS-1:0] al_vld;
    line_t  al_uop;
    logic [CNT_W-1:0] al_total;
    line_t  out_line_q;

    assign a0 = '{vld: acc0_valid, set: acc0_set, mask: acc0_mask, ofs: acc0_ofs};
    assign a1 = '{vld: acc1_valid, set: acc1_set, mask: acc1_mask, ofs: acc1_ofs};

    ufa_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .acc0     (a0),
        .acc1     (a1),
        .ready    (acc_ready),
        .first    (first),
        .second   (second),
        .conflict (conflict)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_route
        assign bank_set[b] = first.mask[b] ? first.set : second.set;
    end

    ufa_bank_array u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_bank (wr_bank),
        .wr_slot (wr_slot),
        .wr_uop  (wr_uop),
        .rd_set  (bank_set),
        .rd_rows (rows)
    );

    ufa_bank_reorder u_reo_a (
        .vld  (first.vld),
        .mask (first.mask),
        .ofs  (first.ofs),
        .rows (rows),
        .blk  (blk_a)
    );

    ufa_bank_reorder u_reo_b (
        .vld  (second.vld),
        .mask (second.mask),
        .ofs  (second.ofs),
        .rows (rows),
        .blk  (blk_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_a_q    <= '0;
            s1_b_q    <= '0;
            s1_conf_q <= 1'b0;
        end else begin
            s1_a_q    <= blk_a;
            s1_b_q    <= blk_b;
            s1_conf_q <= conflict;
        end
    end

    ufa_align u_align (
        .a_cnt    (s1_a_q.cnt),
        .a_rev    (s1_a_q.rev),
        .b_cnt    (s1_b_q.cnt),
        .b_rev    (s1_b_q.rev),
        .slot_vld (al_vld),
        .slot_uop (al_uop),
        .total    (al_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= '0;
            out_line_q     <= '0;
            out_count      <= '0;
            out_conflict   <= 1'b0;
            out_offset_err <= 1'b0;
        end else begin
            out_valid      <= al_vld;
            out_line_q     <= al_uop;
            out_count      <= al_total;
            out_conflict   <= s1_conf_q;
            out_offset_err <= s1_a_q.err | s1_b_q.err;
        end
    end

    assign out_uops = out_line_q;
endmodule

// File: rtl/ufa_checker.sv
module ufa_checker
    import ufa_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       acc0_valid,
    input logic [NUM_BANKS-1:0]       acc0_mask,
    input logic [CNT_W-1:0]           acc0_ofs,
    input logic                       acc1_valid,
    input logic [NUM_BANKS-1:0]       acc1_mask,
    input logic                       acc_ready,
    input logic [LINE_UOPS-1:0]       out_valid,
    input logic [LINE_UOPS*UOP_W-1:0] out_uops,
    input logic [CNT_W-1:0]           out_count,
    input logic                       out_offset_err
);
    logic empty_zero;

    always_comb begin
        empty_zero = 1'b1;
        for (int j = 0; j < LINE_UOPS; j++) begin
            if (!out_valid[j] && out_uops[j*UOP_W +: UOP_W] != '0) empty_zero = 1'b0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && out_count == '0 && acc_ready));

    p_conflict_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_ready && acc0_valid && acc1_valid && |(acc0_mask & acc1_mask)) |=> !acc_ready);

    p_stall_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        !acc_ready |=> acc_ready);

    p_packed_slots_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid & (out_valid + LINE_UOPS'(1))) == '0);

    p_count_matches_r9: assert property (@(posedge clk) disable iff (rst)
        int'(out_count) == $countones(out_valid));

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (rst)
        empty_zero);

    p_offset_err_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_ready && acc0_valid && int'(acc0_ofs) > BANK_UOPS * $countones(acc0_mask))
        |=> ##1 out_offset_err);
endmodule

bind uop_fetch_aligner ufa_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .acc0_valid     (acc0_valid),
    .acc0_mask      (acc0_mask),
    .acc0_ofs       (acc0_ofs),
    .acc1_valid     (acc1_valid),
    .acc1_mask      (acc1_mask),
    .acc_ready      (acc_ready),
    .out_valid      (out_valid),
    .out_uops       (out_uops),
    .out_count      (out_count),
    .out_offset_err (out_offset_err)
);

// File: tb/uop_fetch_aligner_tb_top.sv
module uop_fetch_aligner_tb_top;
    import ufa_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc0_valid = 0, acc1_valid = 0;
    logic [SET_W-1:0] acc0_set = '0, acc1_set = '0;
    logic [NUM_BANKS-1:0] acc0_mask = '0, acc1_mask = '0;
    logic [CNT_W-1:0] acc0_ofs = '0, acc1_ofs = '0;
    logic acc_ready;
    logic wr_en = 0;
    logic [SET_W-1:0] wr_set = '0;
    logic [BANK_W-1:0] wr_bank = '0;
    logic [SLOT_W-1:0] wr_slot = '0;
    logic [UOP_W-1:0] wr_uop = '0;
    logic [LINE_UOPS-1:0] out_valid;
    logic [LINE_UOPS*UOP_W-1:0] out_uops;
    logic [CNT_W-1:0] out_count;
    logic out_conflict, out_offset_err;

    always #5 clk = ~clk;

    uop_fetch_aligner dut_i (.*);

    int checks = 0;
    int errors = 0;
    logic [UOP_W-1:0] shadow [NUM_SETS][NUM_BANKS][BANK_UOPS];
    logic [LINE_UOPS-1:0] ex_v;
    logic [UOP_W-1:0] ex_d [LINE_UOPS];
    int ex_n;
    logic ex_err, ex_conf;

    task automatic chk(string tag, logic [UOP_W-1:0] act, logic [UOP_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_clear();
        ex_v = '0; ex_n = 0; ex_err = 0; ex_conf = 0;
        for (int j = 0; j < LINE_UOPS; j++) ex_d[j] = '0;
    endtask

    // Expected uops from the storage rule of R2/R3: reversed position p is
    // slot p%4 of the (p/4)-th selected bank, ascending.
    task automatic exp_add(int set, logic [NUM_BANKS-1:0] mask, int ofs);
        int nb, seen, bank, p;
        nb = 0;
        for (int b = 0; b < NUM_BANKS; b++) if (mask[b]) nb++;
        if (ofs > nb * BANK_UOPS) begin
            ex_err = 1;
        end else begin
            for (int j = 0; j < ofs; j++) begin
                p = ofs - 1 - j;
                seen = 0; bank = 0;
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (mask[b]) begin
                        if (seen == p / BANK_UOPS) bank = b;
                        seen++;
                    end
                end
                ex_d[ex_n] = shadow[set][bank][p % BANK_UOPS];
                ex_v[ex_n] = 1'b1;
                ex_n++;
            end
        end
    endtask

    task automatic check_out(string tag);
        chk({tag, " valid"}, UOP_W'(out_valid), UOP_W'(ex_v));
        chk({tag, " count"}, UOP_W'(out_count), UOP_W'(ex_n));
        chk({tag, " conflict"}, UOP_W'(out_conflict), UOP_W'(ex_conf));
        chk({tag, " offset_err"}, UOP_W'(out_offset_err), UOP_W'(ex_err));
        for (int j = 0; j < LINE_UOPS; j++)
            chk($sformatf("%s slot%0d", tag, j), out_uops[j*UOP_W +: UOP_W], ex_d[j]);
    endtask

    task automatic drive(logic v0, int s0, logic [3:0] m0, int o0,
                         logic v1, int s1, logic [3:0] m1, int o1);
        acc0_valid = v0; acc0_set = SET_W'(s0); acc0_mask = m0; acc0_ofs = CNT_W'(o0);
        acc1_valid = v1; acc1_set = SET_W'(s1); acc1_mask = m1; acc1_ofs = CNT_W'(o1);
    endtask

    task automatic idle_inputs();
        drive(0, 0, 4'b0, 0, 0, 0, 4'b0, 0);
    endtask

    // Drive at a negedge, check two edges later (R4).
    task automatic issue_and_check(string tag, logic v0, int s0, logic [3:0] m0, int o0,
                                   logic v1, int s1, logic [3:0] m1, int o1);
        exp_clear();
        if (v0) exp_add(s0, m0, o0);
        if (v1) exp_add(s1, m1, o1);
        drive(v0, s0, m0, o0, v1, s1, m1, o1);
        @(negedge clk);
        idle_inputs();
        chk({tag, " R4 not early"}, UOP_W'(out_valid), '0);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic write_uop(int s, int b, int u, logic [UOP_W-1:0] d);
        wr_en = 1; wr_set = SET_W'(s); wr_bank = BANK_W'(b); wr_slot = SLOT_W'(u); wr_uop = d;
        @(negedge clk);
        wr_en = 0;
        shadow[s][b][u] = d;
    endtask

    task automatic t_reset();
        chk("R1 valid", UOP_W'(out_valid), '0);
        chk("R1 count", UOP_W'(out_count), '0);
        chk("R1 ready", UOP_W'(acc_ready), 16'd1);
        chk("R1 flags", UOP_W'({out_conflict, out_offset_err}), '0);
        chk("R1 data", out_uops[UOP_W-1:0], '0);
    endtask

    task automatic t_fill();
        for (int s = 0; s < NUM_SETS; s++)
            for (int b = 0; b < NUM_BANKS; b++)
                for (int u = 0; u < BANK_UOPS; u++)
                    write_uop(s, b, u, UOP_W'(((s + 1) << 12) | (b << 8) | (u << 4) | 5));
    endtask

    task automatic t_single();
        issue_and_check("R2 one bank", 1, 1, 4'b0001, 4, 0, 0, 4'b0, 0);
        issue_and_check("R3 partial entry", 1, 0, 4'b0110, 6, 0, 0, 4'b0, 0);
        issue_and_check("R2 full line", 1, 3, 4'b1111, 16, 0, 0, 4'b0, 0);
    endtask

    task automatic t_sparse();
        issue_and_check("R10 gap mask", 1, 2, 4'b1010, 7, 0, 0, 4'b0, 0);
    endtask

    task automatic t_pair();
        issue_and_check("R5 pair", 1, 0, 4'b0011, 5, 1, 0, 4'b1100, 8);
        issue_and_check("R6 two sets", 1, 1, 4'b0100, 3, 1, 3, 4'b1001, 8);
    endtask

    task automatic t_conflict();
        exp_clear();
        exp_add(2, 4'b0011, 6);
        ex_conf = 1;
        drive(1, 2, 4'b0011, 6, 1, 1, 4'b0110, 5);
        @(negedge clk);
        chk("R7 ready low", UOP_W'(acc_ready), '0);
        drive(1, 0, 4'b1000, 4, 0, 0, 4'b0, 0);   // must be ignored
        @(negedge clk);
        idle_inputs();
        check_out("R7 first only");
        chk("R7 ready back", UOP_W'(acc_ready), 16'd1);
        exp_clear();
        exp_add(1, 4'b0110, 5);
        @(negedge clk);
        check_out("R7 second deferred");
        @(negedge clk);
        chk("R7 ignored access", UOP_W'(out_valid), '0);
    endtask

    task automatic t_offset_err();
        issue_and_check("R8 first bad", 1, 0, 4'b0001, 5, 1, 1, 4'b0010, 2);
        issue_and_check("R8 empty mask", 1, 0, 4'b0000, 1, 0, 0, 4'b0, 0);
        issue_and_check("R8 second bad", 1, 3, 4'b0101, 3, 1, 2, 4'b1000, 9);
    endtask

    task automatic t_zero_ofs();
        issue_and_check("R9 zero offset", 1, 1, 4'b0011, 0, 0, 0, 4'b0, 0);
        issue_and_check("R9 short pair", 1, 2, 4'b0001, 1, 1, 0, 4'b0010, 1);
    endtask

    task automatic t_write();
        write_uop(2, 1, 3, 16'h7E57);
        issue_and_check("R11 fresh write", 1, 2, 4'b0010, 4, 0, 0, 4'b0, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        issue_and_check("R1 array cleared", 1, 0, 4'b1111, 16, 0, 0, 4'b0, 0);
        t_fill();
        t_single();
        t_sparse();
        t_pair();
        t_conflict();
        t_offset_err();
        t_zero_ofs();
        t_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NUM_SETS; s++)
            for (int b = 0; b < NUM_BANKS; b++)
                for (int u = 0; u < BANK_UOPS; u++)
                    shadow[s][b][u] = '0;
    end
endmodule